// File: doc/BRIEF.md
# Monitor Channel Response Transmitter

This block sends the bytes of a read response upstream over a frame-based monitor channel. Once per frame a strobe marks the frame boundary. At each boundary the block samples the downstream acknowledge bit and the downstream monitor byte, and it may change the upstream strobe and the upstream data byte. Both handshake bits are active low. The channel is idle when both stay high.

A message starts with a `start` pulse. The block then asks a byte source for data over a request/valid handshake. It holds each byte on the line with the upstream strobe low until the host acknowledges it. An acknowledge is a high-to-low transition of the downstream MR bit, and the byte must already have been on the line for at least two frames. After an acknowledge the strobe goes high for exactly one frame before the next byte. When the source reports that no data remains, the strobe stays high for two frames, which marks end of message, and `msg_done` pulses.

While a byte is on the line the host must send the all-ones fill value downstream. Any other value seen at a frame boundary is a collision. On a collision the block aborts: the strobe returns high, `abort_pulse` pulses and the block goes back to idle.

States: IDLE, FETCH (byte requested), LOAD (byte held, waiting for the frame boundary), SEND (strobe low, byte on the line), EOM (strobe high, counting end-of-message frames). Transitions:
- IDLE→FETCH on start.
- FETCH→LOAD on valid data.
- FETCH→EOM on valid with end.
- LOAD→SEND at a frame tick.
- SEND→FETCH on an accepted acknowledge.
- SEND→IDLE on a collision (abort).
- EOM→IDLE at the last end-of-message tick (done).

Top module: `mchan_tx`

## Requirements
- R1: During and right after reset, `mx_up_n`=1, `mon_up`=8'hFF, `busy`=0, `fetch_req`=0, and `msg_done` and `abort_pulse` are 0.
- R2: A `start` pulse while idle makes `fetch_req`=1 from the next cycle. `fetch_req` stays 1 until `fetch_vld` is seen.
- R3: A byte accepted with `fetch_vld`=1 and `fetch_end`=0 appears at the next frame tick: `mx_up_n`=0 and `mon_up` equals that byte. Before that tick `mx_up_n` stays 1.
- R4: A byte stays on the line for at least two frame ticks. An acknowledge edge seen at the first tick is remembered and takes effect at the second tick.
- R5: An acknowledge is `mr_dn_n`=1 at one frame tick followed by `mr_dn_n`=0 at the next. MR held low continuously does not acknowledge. On an accepted acknowledge, `mx_up_n` returns to 1 at that tick.
- R6: After an acknowledge, `fetch_req`=1. A next byte supplied within that frame is driven (`mx_up_n`=0) at the next tick, so the strobe is high for exactly one frame.
- R7: `fetch_vld` with `fetch_end`=1 keeps `mx_up_n`=1. `msg_done` pulses for one cycle at the second following frame tick, and the block returns to idle (`busy`=0). An empty message behaves the same way.
- R8: In SEND, a `mon_dn` value other than 8'hFF at a frame tick causes an abort at that tick: `abort_pulse`=1 for one cycle, `mx_up_n`=1 and `busy`=0.
- R9: Outside SEND (idle, or the inter-byte gap) a `mon_dn` value other than 8'hFF has no effect: no abort occurs.
- R10: `start` is ignored while busy. After the message ends, the block stays idle with `fetch_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe at each frame boundary |
| start | input | 1 | Begin a response message (idle only) |
| fetch_req | output | 1 | Request for the next byte |
| fetch_vld | input | 1 | Source answers the request |
| fetch_end | input | 1 | With fetch_vld: no more data |
| fetch_byte | input | 8 | Next byte to send |
| mx_up_n | output | 1 | Upstream strobe, active low |
| mon_up | output | 8 | Upstream monitor byte |
| mr_dn_n | input | 1 | Downstream acknowledge, active low |
| mon_dn | input | 8 | Downstream monitor byte |
| busy | output | 1 | Block is not idle |
| msg_done | output | 1 | One-cycle pulse at end of message |
| abort_pulse | output | 1 | One-cycle pulse on collision abort |

## Verification
The bench aims at an acknowledge edge that arrives after only one frame. A design that acted on it at once would cut the byte to a single frame, and one that ignored it would hang. It holds MR low across several ticks, which a level-sensitive design would wrongly treat as acknowledges. It puts non-fill bytes downstream both during SEND and during the inter-byte gap, to catch a collision check that is missing or that fires too widely. It also times the one-frame gap and the two-frame end of message, since an extra or missing frame would turn a byte boundary into an end of message or the reverse.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_SEND  = 3'd3,
        ST_EOM   = 3'd4
    } mctx_state_e;
endpackage

// File: rtl/mctx_line_mon.sv
module mctx_line_mon #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          mr_dn_n,
    input  logic [DW-1:0] mon_dn,
    output logic          ack_edge,
    output logic          collide
);
    logic mr_q;

    // MR as seen at the previous frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)          mr_q <= 1'b1;
        else if (frame_tick) mr_q <= mr_dn_n;
    end

    always_comb begin
        ack_edge = frame_tick && mr_q && !mr_dn_n;
        collide  = frame_tick && (mon_dn != {DW{1'b1}});
    end
endmodule

// File: rtl/mctx_frame_cnt.sv
module mctx_frame_cnt #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_lim
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign at_lim = (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n || clr)      cnt <= '0;
        else if (inc && !at_lim) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mctx_fsm.sv
module mctx_fsm
    import mctx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          start,
    input  logic          fetch_vld,
    input  logic          fetch_end,
    input  logic [DW-1:0] fetch_byte,
    input  logic          ack_edge,
    input  logic          collide,
    input  logic          hold_done,
    input  logic          eom_last,
    output logic          in_send,
    output logic          in_eom,
    output logic          fetch_req,
    output logic          mx_up_n,
    output logic [DW-1:0] mon_up,
    output logic          busy,
    output logic          msg_done,
    output logic          abort_pulse
);
    mctx_state_e   st, st_nx;
    logic [DW-1:0] byte_q;
    logic          ack_seen;
    logic          release_ok;

    assign release_ok = frame_tick && (ack_edge || ack_seen) && hold_done;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_FETCH;
            ST_FETCH: if (fetch_vld) st_nx = fetch_end ? ST_EOM : ST_LOAD;
            ST_LOAD:  if (frame_tick) st_nx = ST_SEND;
            ST_SEND: begin
                if (collide)         st_nx = ST_IDLE;
                else if (release_ok) st_nx = ST_FETCH;
            end
            ST_EOM:   if (frame_tick && eom_last) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register and the registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            byte_q      <= '1;
            ack_seen    <= 1'b0;
            msg_done    <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            st          <= st_nx;
            if (st == ST_FETCH && fetch_vld && !fetch_end) byte_q <= fetch_byte;
            ack_seen    <= (st == ST_SEND) && (st_nx == ST_SEND) && (ack_seen || ack_edge);
            msg_done    <= (st == ST_EOM) && frame_tick && eom_last;
            abort_pulse <= (st == ST_SEND) && collide;
        end
    end

    // outputs decoded from the state
    always_comb begin
        in_send   = (st == ST_SEND);
        in_eom    = (st == ST_EOM);
        fetch_req = (st == ST_FETCH);
        busy      = (st != ST_IDLE);
        mx_up_n   = !in_send;
        mon_up    = in_send ? byte_q : {DW{1'b1}};
    end

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (mx_up_n && !busy)); // R8
    AST_COLLIDE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_send && collide) |=> abort_pulse); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_pulse && msg_done)); // R7
    AST_MX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_tick) |-> $stable(mx_up_n)); // R3
    AST_HOLD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_send && frame_tick && !hold_done && !collide) |=> !mx_up_n); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_vld) |=> fetch_req); // R2
endmodule

// File: rtl/mchan_tx.sv
module mchan_tx #(
    parameter int DW         = 8,
    parameter int MIN_FRAMES = 2,
    parameter int EOM_FRAMES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          start,
    output logic          fetch_req,
    input  logic          fetch_vld,
    input  logic          fetch_end,
    input  logic [DW-1:0] fetch_byte,
    output logic          mx_up_n,
    output logic [DW-1:0] mon_up,
    input  logic          mr_dn_n,
    input  logic [DW-1:0] mon_dn,
    output logic          busy,
    output logic          msg_done,
    output logic          abort_pulse
);
    localparam int HOLD_LIM = (MIN_FRAMES < 2) ? 1 : MIN_FRAMES - 1;
    localparam int EOM_LIM  = (EOM_FRAMES < 2) ? 1 : EOM_FRAMES - 1;

    logic ack_edge, collide, hold_done, eom_last, in_send, in_eom;

    mctx_line_mon #(.DW(DW)) u_line (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .mr_dn_n(mr_dn_n), .mon_dn(mon_dn),
        .ack_edge(ack_edge), .collide(collide)
    );

    mctx_frame_cnt #(.LIMIT(HOLD_LIM)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(!in_send),
        .inc(frame_tick && in_send), .at_lim(hold_done)
    );

    mctx_frame_cnt #(.LIMIT(EOM_LIM)) u_eom (
        .clk(clk), .rst_n(rst_n), .clr(!in_eom),
        .inc(frame_tick && in_eom), .at_lim(eom_last)
    );

    mctx_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .start(start),
        .fetch_vld(fetch_vld), .fetch_end(fetch_end), .fetch_byte(fetch_byte),
        .ack_edge(ack_edge), .collide(collide),
        .hold_done(hold_done), .eom_last(eom_last),
        .in_send(in_send), .in_eom(in_eom), .fetch_req(fetch_req),
        .mx_up_n(mx_up_n), .mon_up(mon_up), .busy(busy),
        .msg_done(msg_done), .abort_pulse(abort_pulse)
    );
endmodule

// File: tb/mchan_tx_bench.sv
module mchan_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 8;
    // {data byte, downstream byte during the first frame}
    localparam logic [15:0] VEC [0:3] = '{16'hA5FF, 16'h3C00, 16'hFFFF, 16'h00FE};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       start = 1'b0;
    logic       fetch_vld = 1'b0;
    logic       fetch_end = 1'b0;
    logic [7:0] fetch_byte = 8'h00;
    logic       mr_dn_n = 1'b1;
    logic [7:0] mon_dn = 8'hFF;
    logic       fetch_req, mx_up_n, busy, msg_done, abort_pulse;
    logic [7:0] mon_up;
    int         fc = 0;
    int         n_run = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        fc         <= (fc == FRAME-1) ? 0 : fc + 1;
        frame_tick <= (fc == FRAME-2);
    end

    mchan_tx u_mchan_tx (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .start(start),
        .fetch_req(fetch_req), .fetch_vld(fetch_vld), .fetch_end(fetch_end),
        .fetch_byte(fetch_byte), .mx_up_n(mx_up_n), .mon_up(mon_up),
        .mr_dn_n(mr_dn_n), .mon_dn(mon_dn), .busy(busy),
        .msg_done(msg_done), .abort_pulse(abort_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic pass_tick();
        do @(posedge clk); while (frame_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic serve(input logic [7:0] b, input logic last);
        while (!fetch_req) @(negedge clk);
        fetch_vld = 1'b1; fetch_end = last; fetch_byte = b;
        @(negedge clk);
        fetch_vld = 1'b0; fetch_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 mx_up_n in reset", mx_up_n, 1);
        chk("R1 mon_up in reset", mon_up, 8'hFF);
        chk("R1 busy/req/pulses in reset", {busy, fetch_req, msg_done, abort_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {mx_up_n, busy, fetch_req}, 3'b100);

        // R9: non-fill downstream byte while idle
        mon_dn = 8'h00;
        pass_tick(); pass_tick();
        chk("R9 no abort while idle", abort_pulse, 0);
        mon_dn = 8'hFF;

        // table walk: single-byte messages, some with a collision
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            logic [7:0] dn;
            d  = VEC[i][15:8];
            dn = VEC[i][7:0];
            kick();
            chk("R2 fetch_req after start", fetch_req, 1);
            serve(d, 1'b0);
            chk("R3 mx inactive before tick", mx_up_n, 1);
            pass_tick();
            chk("R3 mx active at tick", mx_up_n, 0);
            chk("R3 byte on line", mon_up, d);
            mon_dn = dn;
            pass_tick();
            if (dn != 8'hFF) begin
                chk("R8 abort pulse", abort_pulse, 1);
                chk("R8 mx released", mx_up_n, 1);
                mon_dn = 8'hFF;
                @(negedge clk);
                chk("R8 idle after abort", {busy, abort_pulse}, 0);
                continue;
            end
            chk("R8 no abort on fill", abort_pulse, 0);
            chk("R4 byte held after one frame", mx_up_n, 0);
            mr_dn_n = 1'b0;
            pass_tick();
            chk("R5 ack releases mx", mx_up_n, 1);
            chk("R6 next byte requested", fetch_req, 1);
            mr_dn_n = 1'b1;
            serve(8'h00, 1'b1);
            pass_tick();
            chk("R7 no done after one eom frame", {msg_done, mx_up_n}, 2'b01);
            pass_tick();
            chk("R7 done after two eom frames", msg_done, 1);
            chk("R7 idle after done", busy, 0);
        end

        // R4: early acknowledge, R6 gap, R9 gap, R5 held-low MR, R10
        kick();
        serve(8'h5A, 1'b0);
        pass_tick();
        mr_dn_n = 1'b0;
        pass_tick();
        chk("R4 early ack does not release", mx_up_n, 0);
        pass_tick();
        chk("R4 remembered ack releases at second tick", mx_up_n, 1);
        mon_dn = 8'h00;
        serve(8'hC3, 1'b0);
        pass_tick();
        chk("R9 no abort in gap", abort_pulse, 0);
        chk("R6 next byte after one-frame gap", {mx_up_n, mon_up}, {1'b0, 8'hC3});
        mon_dn = 8'hFF;
        kick();
        pass_tick(); pass_tick(); pass_tick();
        chk("R5 held-low MR is no ack", mx_up_n, 0);
        mr_dn_n = 1'b1;
        pass_tick();
        mr_dn_n = 1'b0;
        pass_tick();
        chk("R5 fresh edge acknowledges", mx_up_n, 1);
        mr_dn_n = 1'b1;
        serve(8'h00, 1'b1);
        pass_tick(); pass_tick();
        chk("R7 done after multi-byte", msg_done, 1);
        repeat (3) @(negedge clk);
        chk("R10 start while busy ignored", {busy, fetch_req}, 0);

        // R7: empty message
        kick();
        serve(8'h00, 1'b1);
        chk("R7 empty message keeps mx high", mx_up_n, 1);
        pass_tick();
        chk("R7 empty no early done", msg_done, 0);
        pass_tick();
        chk("R7 empty done", msg_done, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule